// File: doc/BRIEF.md
# Multi-Link ATM Cell Input Port (Transmit-Direction Bus, Receiver Side)

This block is the receiving end of a cell-level-handshake ATM bus on which an ATM-layer master pushes cells towards several physical links. Each link has a programmable 5-bit bus address and an enable bit. Every clock the master presents an address. In the next cycle the block answers on a cell-available line: high if the shared cell buffer has room, low if it is full. If no enabled link owns that address, the line is released, which means its output enable is dropped.

A cycle in which the transfer enable is low is an address cycle, and it also latches which link is selected. Words presented while the transfer enable is high go to the selected link. A start-of-cell pulse on an idle framer opens a cell of 53 bytes: 53 words on an 8-bit bus, or 27 words on a 16-bit bus. Every word is checked for odd or even parity. A cell that begins while the shared buffer is full is consumed from the bus but never written, and a sticky "no free cell" flag records that this happened. The block emits a write stream of data, byte enables and link number, together with a cell-done pulse, for a downstream cell store. A drain pulse frees one buffer slot.

Top module: `utopia_cell_inport`

## Requirements
- R1: Bus address 31 never matches any link, even when a link is enabled with address 31.
- R2: Only links whose enable bit is set can match. When several enabled links share the address, the lowest-numbered link wins.
- R3: One cycle after an address is presented that matches an enabled link, `clav_oe` is 1 and `clav` is 1 exactly when the buffer occupancy sampled in that cycle is below `BUF_CELLS`.
- R4: One cycle after an address that matches no enabled link is presented, `clav_oe` is 0 and `clav` is 0. Both are 0 after reset.
- R5: A cycle with `tx_en`=0 latches the selection: the matched link, or no link. A word is taken only in a cycle with `tx_en`=1 while a link is selected.
- R6: With the framer idle, a taken word with `tx_soc`=1 opens a cell of 53 words (8-bit bus) or 27 words (16-bit bus). A taken word with `tx_soc`=0 while idle produces no write. Each accepted word appears on `wr_data`, with `wr_valid`=1 and the cell's link number on `wr_link`, one cycle after it is taken.
- R7: `tx_soc` is ignored on every word after the first word of an open cell. Framing continues and the cell length is unchanged.
- R8: A cell whose first word arrives while occupancy equals `BUF_CELLS` is refused. None of its words is written, and all of its words are still consumed.
- R9: A refusal sets `full_flag` in the next cycle. `full_clr`=1 clears the flag, and a refusal in the same cycle takes priority over the clear.
- R10: Occupancy rises by one when a cell is accepted at its first word and falls by one on `cell_drain` when it is non-zero. Both in one cycle leave it unchanged. `cell_done` pulses one cycle after the last word of an accepted cell.
- R11: A taken word passes parity when the XOR of the data bits and `tx_par` equals `cfg_odd_par` (1 = odd). On a failure, `par_err` carries a one-hot bit for the selected link in the next cycle, and is zero otherwise.
- R12: On the 16-bit bus, `wr_be` is 2'b01 for word index 5 (counting from 0), which drops the upper byte, and 2'b11 for every other word. On the 8-bit bus it is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_link_addr | input | 5*NLINK | Bus address of each link, link i in bits [5i+4:5i] |
| cfg_link_en | input | NLINK | Per-link address enable |
| cfg_odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| bus_addr | input | 5 | Address presented by the master |
| tx_en | input | 1 | Transfer enable; 0 marks an address/selection cycle |
| tx_soc | input | 1 | Start-of-cell marker |
| tx_data | input | DATA_W | Cell data word |
| tx_par | input | 1 | Parity bit for tx_data |
| cell_drain | input | 1 | Frees one slot of the shared buffer |
| full_clr | input | 1 | Clears full_flag |
| clav | output | 1 | Cell-available value |
| clav_oe | output | 1 | Drive enable for clav; 0 means released |
| wr_valid | output | 1 | Write strobe toward the cell store |
| wr_data | output | DATA_W | Word to write |
| wr_be | output | DATA_W/8 | Byte enables of the word |
| wr_link | output | clog2(NLINK) | Link that owns the cell |
| cell_done | output | 1 | Pulse at the end of an accepted cell |
| par_err | output | NLINK | One-hot parity error per link |
| full_flag | output | 1 | Sticky "no free cell" status |

## Verification
Two pairs of functions can land on the same clock edge. The first is a cell being accepted, which reserves a buffer slot, together with a drain pulse that frees one. The second is a refused cell, which sets the sticky flag, together with a clear request. The bench forces both collisions by raising `cell_drain` or `full_clr` on exactly the start-of-cell word. It then judges the result by the next poll's `clav` value and by `full_flag`, checked against a behavioural model that is compared on every clock. A start-of-cell pulse injected in the middle of a cell and a parity error on a chosen word are also placed inside the same cells.

// File: rtl/uci_pkg.sv
package uci_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 5'd31;
  localparam int CELL_BYTES = 53;

  // Bus words per cell: a 16-bit bus carries one padded byte.
  function automatic int words_per_cell(input int dw);
    return (dw == 16) ? (CELL_BYTES + 1) / 2 : CELL_BYTES;
  endfunction
endpackage

// File: rtl/uci_addr_match.sv
module uci_addr_match #(
  parameter int NLINK  = 4,
  parameter int LINK_W = 2
) (
  input  logic [NLINK*uci_pkg::ADDR_W-1:0] cfg_link_addr,
  input  logic [NLINK-1:0]                 cfg_link_en,
  input  logic [uci_pkg::ADDR_W-1:0]       bus_addr,
  output logic                             hit,
  output logic [LINK_W-1:0]                hit_idx
);
  localparam int AW = uci_pkg::ADDR_W;

  logic [NLINK-1:0] link_eq;

  for (genvar g = 0; g < NLINK; g++) begin : g_cmp
    assign link_eq[g] = cfg_link_en[g] &&
                        (cfg_link_addr[g*AW +: AW] == bus_addr) &&
                        (bus_addr != uci_pkg::NULL_ADDR);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NLINK - 1; i >= 0; i--) begin
      if (link_eq[i]) begin
        hit     = 1'b1;
        hit_idx = LINK_W'(i);
      end
    end
  end
endmodule

// File: rtl/uci_occ_tracker.sv
module uci_occ_tracker #(
  parameter int BUF_CELLS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reserve,
  input  logic drain,
  input  logic refuse,
  input  logic clr,
  output logic full,
  output logic full_flag
);
  localparam int OW = $clog2(BUF_CELLS + 1);

  logic [OW-1:0] occ;
  logic          drain_eff;

  assign drain_eff = drain && (occ != '0);
  assign full      = (occ == OW'(BUF_CELLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      case ({reserve, drain_eff})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full_flag <= 1'b0;
    else if (refuse) full_flag <= 1'b1;
    else if (clr)    full_flag <= 1'b0;
  end

  // R10: occupancy never exceeds the buffer size
  a_r10_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(BUF_CELLS));

  // R10: simultaneous reserve and drain leave occupancy unchanged
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (reserve && drain_eff) |=> $stable(occ));

  // R9: a refusal always leaves the sticky flag set, even against a clear
  a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> full_flag);
endmodule

// File: rtl/uci_framer.sv
module uci_framer #(
  parameter int NLINK    = 4,
  parameter int LINK_W   = 2,
  parameter int DATA_W   = 8,
  parameter int PAD_WORD = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              soc,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  logic              odd_par,
  input  logic [LINK_W-1:0] sel_idx,
  input  logic              full,
  output logic              reserve,
  output logic              refuse,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W/8-1:0] wr_be,
  output logic [LINK_W-1:0] wr_link,
  output logic              cell_done,
  output logic [NLINK-1:0]  par_err
);
  localparam int WORDS = uci_pkg::words_per_cell(DATA_W);
  localparam int CW    = $clog2(WORDS);
  localparam int BE_W  = DATA_W / 8;

  function automatic logic parity_ok(input logic [DATA_W-1:0] d, input logic p,
                                     input logic odd);
    return (^{d, p}) == odd;
  endfunction

  function automatic logic [BE_W-1:0] be_for(input int w);
    logic [BE_W-1:0] be;
    be = '1;
    if (BE_W > 1 && w == PAD_WORD) be[BE_W-1] = 1'b0;
    return be;
  endfunction

  logic [CW-1:0]     cnt;
  logic              in_cell;
  logic              drop;
  logic [LINK_W-1:0] cell_link;

  // Named events for the checks below.
  logic start_evt, mid_evt, last_word, soc_ignored;
  assign start_evt   = xfer && !in_cell && soc;
  assign mid_evt     = xfer && in_cell;
  assign last_word   = (cnt == CW'(WORDS - 1));
  assign soc_ignored = mid_evt && soc;
  assign reserve     = start_evt && !full;
  assign refuse      = start_evt && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      in_cell   <= 1'b0;
      drop      <= 1'b0;
      cell_link <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      wr_be     <= '0;
      wr_link   <= '0;
      cell_done <= 1'b0;
      par_err   <= '0;
    end else begin
      wr_valid  <= 1'b0;
      cell_done <= 1'b0;
      par_err   <= '0;
      if (xfer && !parity_ok(data, par, odd_par))
        par_err <= {{(NLINK-1){1'b0}}, 1'b1} << sel_idx;
      if (start_evt) begin
        in_cell   <= 1'b1;
        cnt       <= CW'(1);
        drop      <= full;
        cell_link <= sel_idx;
        wr_valid  <= !full;
        wr_data   <= data;
        wr_be     <= be_for(0);
        wr_link   <= sel_idx;
      end else if (mid_evt) begin
        wr_valid <= !drop;
        wr_data  <= data;
        wr_be    <= be_for(int'(cnt));
        wr_link  <= cell_link;
        if (last_word) begin
          in_cell   <= 1'b0;
          cnt       <= '0;
          cell_done <= !drop;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: the word counter stays inside one cell
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WORDS - 1));

  // R7: a start marker inside a cell neither restarts nor stalls the count
  a_r7_soc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_ignored && !last_word) |=> (cnt == $past(cnt) + 1'b1) && in_cell);

  // R8: the first word of a refused cell is never written
  a_r8_refused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> !wr_valid);
endmodule

// File: rtl/utopia_cell_inport.sv
module utopia_cell_inport #(
  parameter int NLINK     = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_CELLS = 4,
  parameter int PAD_WORD  = 5,
  localparam int AW       = uci_pkg::ADDR_W,
  localparam int LINK_W   = (NLINK > 1) ? $clog2(NLINK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINK*AW-1:0]   cfg_link_addr,
  input  logic [NLINK-1:0]      cfg_link_en,
  input  logic                  cfg_odd_par,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  tx_en,
  input  logic                  tx_soc,
  input  logic [DATA_W-1:0]     tx_data,
  input  logic                  tx_par,
  input  logic                  cell_drain,
  input  logic                  full_clr,
  output logic                  clav,
  output logic                  clav_oe,
  output logic                  wr_valid,
  output logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W/8-1:0]   wr_be,
  output logic [LINK_W-1:0]     wr_link,
  output logic                  cell_done,
  output logic [NLINK-1:0]      par_err,
  output logic                  full_flag
);
  logic              hit;
  logic [LINK_W-1:0] hit_idx;
  logic              sel_v;
  logic [LINK_W-1:0] sel_idx;
  logic              buf_full;
  logic              reserve, refuse;
  logic              xfer;

  uci_addr_match #(.NLINK(NLINK), .LINK_W(LINK_W)) u_match (
    .cfg_link_addr (cfg_link_addr),
    .cfg_link_en   (cfg_link_en),
    .bus_addr      (bus_addr),
    .hit           (hit),
    .hit_idx       (hit_idx)
  );

  // Poll response for the address seen on the previous edge; selection
  // follows the address on every non-transfer cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav    <= 1'b0;
      clav_oe <= 1'b0;
      sel_v   <= 1'b0;
      sel_idx <= '0;
    end else begin
      clav_oe <= hit;
      clav    <= hit && !buf_full;
      if (!tx_en) begin
        sel_v   <= hit;
        sel_idx <= hit_idx;
      end
    end
  end

  assign xfer = tx_en && sel_v;

  uci_framer #(.NLINK(NLINK), .LINK_W(LINK_W), .DATA_W(DATA_W),
               .PAD_WORD(PAD_WORD)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .soc       (tx_soc),
    .data      (tx_data),
    .par       (tx_par),
    .odd_par   (cfg_odd_par),
    .sel_idx   (sel_idx),
    .full      (buf_full),
    .reserve   (reserve),
    .refuse    (refuse),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .wr_link   (wr_link),
    .cell_done (cell_done),
    .par_err   (par_err)
  );

  uci_occ_tracker #(.BUF_CELLS(BUF_CELLS)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .reserve   (reserve),
    .drain     (cell_drain),
    .refuse    (refuse),
    .clr       (full_clr),
    .full      (buf_full),
    .full_flag (full_flag)
  );

  // R1: the reserved address never gets a driven answer
  a_r1_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_addr) == uci_pkg::NULL_ADDR) |-> !clav_oe);

  // R4: an unmatched poll releases the line on the next cycle
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!clav_oe && !clav));

  // R5: no write follows a transfer cycle without a selected link
  a_r5_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !sel_v) |=> !wr_valid);

  // R11: parity error reporting stays one-hot
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(par_err));
endmodule

// File: tb/tb_utopia_cell_inport.sv
`timescale 1ns/1ps
module tb_utopia_cell_inport;
  localparam int NL = 4;
  localparam int BUF = 2;
  localparam int WORDS = 53;
  localparam int WORDS16 = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] cfg_a [NL];
  logic [NL*5-1:0] cfg_link_addr;
  logic [NL-1:0] cfg_link_en;
  logic cfg_odd_par;
  logic [4:0] bus_addr;
  logic tx_en, tx_soc, tx_par, cell_drain, full_clr;
  logic [7:0] tx_data;
  logic clav, clav_oe, wr_valid, cell_done, full_flag;
  logic [7:0] wr_data;
  logic [0:0] wr_be;
  logic [1:0] wr_link;
  logic [NL-1:0] par_err;

  for (genvar g = 0; g < NL; g++) begin : g_cfg
    assign cfg_link_addr[g*5 +: 5] = cfg_a[g];
  end

  utopia_cell_inport #(.NLINK(NL), .DATA_W(8), .BUF_CELLS(BUF)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_link_addr(cfg_link_addr),
    .cfg_link_en(cfg_link_en), .cfg_odd_par(cfg_odd_par), .bus_addr(bus_addr),
    .tx_en(tx_en), .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par),
    .cell_drain(cell_drain), .full_clr(full_clr), .clav(clav),
    .clav_oe(clav_oe), .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be),
    .wr_link(wr_link), .cell_done(cell_done), .par_err(par_err),
    .full_flag(full_flag));

  // 16-bit instance for the padding check
  logic [4:0] b_addr;
  logic b_en, b_soc, b_par;
  logic [15:0] b_data;
  logic b_clav, b_oe, b_wv, b_done, b_full;
  logic [15:0] b_wd;
  logic [1:0] b_be, b_wl;
  logic [NL-1:0] b_perr;

  utopia_cell_inport #(.NLINK(NL), .DATA_W(16)) dut16 (
    .clk(clk), .rst_n(rst_n), .cfg_link_addr(cfg_link_addr),
    .cfg_link_en(cfg_link_en), .cfg_odd_par(cfg_odd_par), .bus_addr(b_addr),
    .tx_en(b_en), .tx_soc(b_soc), .tx_data(b_data), .tx_par(b_par),
    .cell_drain(1'b0), .full_clr(1'b0), .clav(b_clav), .clav_oe(b_oe),
    .wr_valid(b_wv), .wr_data(b_wd), .wr_be(b_be), .wr_link(b_wl),
    .cell_done(b_done), .par_err(b_perr), .full_flag(b_full));

  int n_chk = 0, n_bad = 0, n_wr = 0, n_perr = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_occ, m_pos, m_link, m_si;
  bit m_drop, m_sv, m_full;
  bit e_clav, e_oe, e_wv, e_done;
  int e_wd, e_wl, e_perr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ <= 0; m_pos <= 0; m_link <= 0; m_si <= 0;
      m_drop <= 0; m_sv <= 0; m_full <= 0;
      e_clav <= 0; e_oe <= 0; e_wv <= 0; e_done <= 0;
      e_wd <= 0; e_wl <= 0; e_perr <= 0;
    end else begin
      int h, hi, res, drn;
      bit fset, xf;
      h = 0; hi = 0; res = 0; fset = 0;
      for (int k = 0; k < NL; k++)
        if (h == 0 && cfg_link_en[k] && cfg_a[k] == bus_addr && bus_addr != 5'd31) begin
          h = 1; hi = k;
        end
      e_oe <= (h != 0);
      e_clav <= (h != 0) && (m_occ < BUF);
      xf = tx_en && m_sv;
      drn = (cell_drain && m_occ > 0) ? 1 : 0;
      e_wv <= 0; e_done <= 0; e_perr <= 0;
      if (xf && ((^{tx_data, tx_par}) != cfg_odd_par)) e_perr <= 1 << m_si;
      if (xf) begin
        if (m_pos == 0) begin
          if (tx_soc) begin
            if (m_occ == BUF) begin m_drop <= 1; fset = 1; end
            else begin m_drop <= 0; res = 1; end
            m_pos <= 1; m_link <= m_si;
            e_wv <= (m_occ != BUF); e_wd <= tx_data; e_wl <= m_si;
          end
        end else begin
          e_wv <= !m_drop; e_wd <= tx_data; e_wl <= m_link;
          if (m_pos == WORDS - 1) begin m_pos <= 0; e_done <= !m_drop; end
          else m_pos <= m_pos + 1;
        end
      end
      m_occ <= m_occ + res - drn;
      if (fset) m_full <= 1; else if (full_clr) m_full <= 0;
      if (!tx_en) begin m_sv <= (h != 0); m_si <= hi; end
    end
  end

  // Per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(clav == e_clav, "R3 clav", clav, e_clav);
      chk(clav_oe == e_oe, "R4 clav_oe", clav_oe, e_oe);
      chk(wr_valid == e_wv, "R8 wr_valid", wr_valid, e_wv);
      if (e_wv) begin
        chk(wr_data == e_wd[7:0], "R6 wr_data", wr_data, e_wd);
        chk(wr_link == e_wl[1:0], "R2 wr_link", wr_link, e_wl);
        chk(wr_be == 1'b1, "R12 wr_be 8-bit", wr_be, 1);
      end
      chk(cell_done == e_done, "R10 cell_done", cell_done, e_done);
      chk(par_err == e_perr[NL-1:0], "R11 par_err", par_err, e_perr);
      chk(full_flag == m_full, "R9 full_flag", full_flag, m_full);
      if (wr_valid) n_wr++;
      if (par_err != 0) n_perr++;
    end
  end

  task automatic poll(input int a);
    tx_en = 0; tx_soc = 0; bus_addr = 5'(a);
    @(negedge clk);
  endtask

  task automatic send_cell(input int a, input int inj, input int bad,
                           input bit clr_soc, input bit drn_soc);
    poll(a);
    for (int i = 0; i < WORDS; i++) begin
      tx_en = 1; bus_addr = 5'd12;
      tx_soc = (i == 0) || (i == inj);
      tx_data = 8'(a * 17 + i * 7);
      tx_par = (^tx_data) ^ cfg_odd_par ^ (i == bad);
      full_clr = clr_soc && (i == 0);
      cell_drain = drn_soc && (i == 0);
      @(negedge clk);
    end
    tx_en = 0; tx_soc = 0; full_clr = 0; cell_drain = 0;
    @(negedge clk);
  endtask

  task automatic pulse_drain();
    cell_drain = 1; @(negedge clk); cell_drain = 0;
  endtask

  initial begin
    int w0, p0;
    cfg_a[0] = 5'd3; cfg_a[1] = 5'd7; cfg_a[2] = 5'd31; cfg_a[3] = 5'd7;
    cfg_link_en = 4'b1111; cfg_odd_par = 1;
    bus_addr = 5'd31; tx_en = 0; tx_soc = 0; tx_data = 0; tx_par = 0;
    cell_drain = 0; full_clr = 0;
    b_addr = 5'd31; b_en = 0; b_soc = 0; b_data = 0; b_par = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(clav_oe == 0, "R4 reset clav_oe", clav_oe, 0);
    chk(full_flag == 0, "R9 reset full_flag", full_flag, 0);

    poll(3);
    chk(clav_oe && clav, "R3 poll enabled link", {clav_oe, clav}, 3);
    poll(31);
    chk(clav_oe == 0, "R1 reserved address", clav_oe, 0);
    poll(12);
    chk(clav_oe == 0 && clav == 0, "R4 unmatched address", {clav_oe, clav}, 0);

    w0 = n_wr;
    send_cell(7, -1, -1, 0, 0);
    chk(n_wr - w0 == WORDS, "R6 cell length", n_wr - w0, WORDS);
    chk(wr_link == 2'd1, "R2 lowest duplicate wins", wr_link, 1);

    w0 = n_wr; p0 = n_perr;
    send_cell(3, 20, 10, 0, 0);
    chk(n_wr - w0 == WORDS, "R7 mid-cell soc ignored", n_wr - w0, WORDS);
    chk(n_perr - p0 == 1, "R11 one parity error", n_perr - p0, 1);

    poll(3);
    chk(clav_oe == 1 && clav == 0, "R3 full buffer", {clav_oe, clav}, 2);

    w0 = n_wr;
    send_cell(3, -1, -1, 1, 0);
    chk(n_wr - w0 == 0, "R8 refused cell", n_wr - w0, 0);
    chk(full_flag == 1, "R9 set wins over clear", full_flag, 1);
    full_clr = 1; @(negedge clk); full_clr = 0;
    chk(full_flag == 0, "R9 clear", full_flag, 0);

    pulse_drain();
    w0 = n_wr;
    send_cell(3, -1, -1, 0, 1);
    chk(n_wr - w0 == WORDS, "R10 accept with drain", n_wr - w0, WORDS);
    poll(3);
    chk(clav == 1, "R10 reserve+drain cancel", clav, 1);
    send_cell(7, -1, -1, 0, 0);
    poll(3);
    chk(clav == 0, "R10 full again", clav, 0);
    pulse_drain(); pulse_drain();

    poll(3);
    w0 = n_wr;
    for (int i = 0; i < 5; i++) begin
      tx_en = 1; tx_soc = 0; tx_data = 8'(i); tx_par = (^tx_data) ^ cfg_odd_par;
      @(negedge clk);
    end
    tx_en = 0; @(negedge clk);
    chk(n_wr - w0 == 0, "R6 stray words", n_wr - w0, 0);

    poll(12);
    w0 = n_wr;
    for (int i = 0; i < 3; i++) begin
      tx_en = 1; tx_soc = 1; tx_data = 8'hA5; @(negedge clk);
    end
    tx_en = 0; tx_soc = 0; @(negedge clk);
    chk(n_wr - w0 == 0, "R5 unselected transfer", n_wr - w0, 0);

    cfg_odd_par = 0;
    w0 = n_wr; p0 = n_perr;
    send_cell(3, -1, 0, 0, 0);
    chk(n_wr - w0 == WORDS, "R11 even mode cell", n_wr - w0, WORDS);
    chk(n_perr - p0 == 1, "R11 even mode error", n_perr - p0, 1);

    cfg_link_en = 4'b1110;
    poll(3);
    chk(clav_oe == 0, "R2 disabled link", clav_oe, 0);
    cfg_link_en = 4'b1111;

    b_en = 0; b_addr = 5'd3; @(negedge clk);
    for (int i = 0; i < WORDS16; i++) begin
      b_en = 1; b_soc = (i == 0); b_data = 16'(i * 259 + 1);
      b_par = (^b_data) ^ cfg_odd_par;
      @(negedge clk);
      chk(b_wv == 1, "R12 16-bit write", b_wv, 1);
      chk(b_be == ((i == 5) ? 2'b01 : 2'b11), "R12 pad byte enable", b_be,
          (i == 5) ? 1 : 3);
    end
    b_en = 0; b_soc = 0; @(negedge clk);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule